// File: doc/BRIEF.md
# System-Management Memory Window Controller

This block holds the control state for system-management memory and decodes each memory access against it. Two byte-wide control registers and one 16-bit extended-size word sit behind a simple configuration write/read port. From them the block decides, for every access address and its mode (ordinary CPU access or system-management-mode access), where the access is routed: ordinary decode, DRAM, the PCI/video space, or a discard hole that reads as all ones.

Three windows are governed. The first is the legacy 128 KiB window at 0xA0000. The second is a high alias of that window at 0xFEDA0000, which reaches the same DRAM bytes. The third is a protected segment just below the top of low DRAM, whose size comes from the extended control byte. A sticky lock bit closes the ordinary-mode view and freezes both control bytes until reset. The extended-size word answers a query code with the segment size the block was built for.

Top module: `smram_guard`

## Requirements
- R1: After reset the control byte (cfgAddr 0) reads 0x00, the extended byte (cfgAddr 1) reads 0x00, and the size word (cfgAddr 2) reads 0xFFFF when the configured extended size is nonzero.
- R2: While unlocked, only control bits 6 (open), 4 (lock) and 3 (global enable) and extended bits 7 (high select), 2:1 (size code) and 0 (segment enable) can be written; all other bits read 0.
- R3: A control write that leaves bit 4 set also clears bit 6 in that same write. From then on neither control byte changes until reset.
- R4: Route codes are 0 pass, 1 DRAM, 2 PCI/video, 3 hole. An ordinary access to 0xA0000..0xBFFFF routes to PCI/video when bit 6 is clear or high select is set, and to DRAM at the same address when bit 6 is set and high select is clear.
- R5: An ordinary access to 0xFEDA0000..0xFEDBFFFF routes to DRAM at (address − 0xFED00000) only when bit 6 and high select are both set, and passes otherwise. A pass route returns ramAddr equal to the access address.
- R6: A system-management access with global enable set reaches DRAM in the legacy window when high select is clear, or in the high window (remapped as in R5) when high select is set. Any other system-management access is decoded as an ordinary one.
- R7: With segment enable clear the protected segment is empty. With it set, size codes 0, 1 and 2 give 1, 2 and 8 MiB, and code 3 gives the configured extended size in MiB.
- R8: An access in [top − size, top) routes to the hole in ordinary mode and to DRAM at the same address in system-management mode.
- R9: Writing 0xFFFF to the size word makes it read back the configured size in MiB. Any other value written reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select for read and write (0 control, 1 extended, 2 size word) |
| cfgWrData | input | 16 | Write data; the byte registers use bits 7:0 |
| cfgRdData | output | 16 | Read data of the selected register, zero-extended |
| accAddr | input | 32 | Access address to decode |
| accSmm | input | 1 | Access is made in system-management mode |
| accRoute | output | 2 | Route code (see R4) |
| ramAddr | output | 32 | DRAM address for a DRAM route, access address otherwise |

## Verification
The hardest state to reach is the locked one. After the lock write, the bench must show that writes which would reopen the window, or change the high select or segment size, leave both the read-back bytes and the routing unchanged. Reaching this needs a lock write that also tries to set the open bit, followed by attempts to write both bytes. A second reset must then bring back full write access. The bench also changes the size code and high select between accesses, so that each window edge is tested one byte inside and one byte outside the window under both access modes.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    ROUTE_PASS = 2'd0,
    ROUTE_RAM  = 2'd1,
    ROUTE_PCI  = 2'd2,
    ROUTE_HOLE = 2'd3
  } route_e;

  localparam int OPEN_BIT = 6;
  localparam int LOCK_BIT = 4;
  localparam int GEN_BIT  = 3;
  localparam int HIGH_BIT = 7;
  localparam int SZ_LO    = 1;
  localparam int TEN_BIT  = 0;

  localparam logic [7:0] CTL_WMASK        = 8'h58;
  localparam logic [7:0] CTL_WMASK_LOCKED = 8'h00;
  localparam logic [7:0] EXT_WMASK        = 8'h87;
  localparam logic [7:0] EXT_WMASK_LOCKED = 8'h00;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_EXT  = 2'd1;
  localparam logic [1:0] SEL_WORD = 2'd2;

  localparam logic [31:0] LEGACY_BASE = 32'h000A_0000;
  localparam logic [31:0] WINDOW_SIZE = 32'h0002_0000;
  localparam logic [31:0] HIGH_BASE   = 32'hFEDA_0000;

  typedef struct packed {
    logic        legacyPci;
    logic        highOpen;
    logic        smmLow;
    logic        smmHigh;
    logic [11:0] tsegMb;
  } win_strobe_t;
endpackage

// File: rtl/smram_ctrl.sv
module smram_ctrl
  import smram_pkg::*;
#(
  parameter int WORD_W          = 16,
  parameter int EXT_TSEG_MB     = 16,
  parameter int EXT_TSEG_MAX_MB = 4095
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] cfgRdData,
  output win_strobe_t       strobe
);
  localparam int EXT_EFF = (EXT_TSEG_MB <= EXT_TSEG_MAX_MB) ? EXT_TSEG_MB : 0;
  localparam logic [WORD_W-1:0] QUERY    = '1;
  localparam logic [WORD_W-1:0] EXT_WORD = WORD_W'(EXT_EFF);
  localparam logic [WORD_W-1:0] WORD_RST = (EXT_EFF > 0) ? QUERY : '0;

  logic [7:0] ctlReg, extReg;
  logic [WORD_W-1:0] wordReg;
  logic [7:0] ctlMask, extMask, ctlNext, extNext;
  logic locked;

  assign locked  = ctlReg[LOCK_BIT];
  assign ctlMask = locked ? CTL_WMASK_LOCKED : CTL_WMASK;
  assign extMask = locked ? EXT_WMASK_LOCKED : EXT_WMASK;

  always_comb begin
    ctlNext = (ctlReg & ~ctlMask) | (cfgWrData[7:0] & ctlMask);
    if (ctlNext[LOCK_BIT]) ctlNext[OPEN_BIT] = 1'b0;
    extNext = (extReg & ~extMask) | (cfgWrData[7:0] & extMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= '0;
      extReg  <= '0;
      wordReg <= WORD_RST;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        SEL_CTL:  ctlReg <= ctlNext;
        SEL_EXT:  extReg <= extNext;
        SEL_WORD: wordReg <= ((EXT_EFF > 0) && (cfgWrData == QUERY)) ? EXT_WORD : cfgWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfgAddr)
      SEL_CTL:  cfgRdData = WORD_W'(ctlReg);
      SEL_EXT:  cfgRdData = WORD_W'(extReg);
      SEL_WORD: cfgRdData = wordReg;
      default:  cfgRdData = '0;
    endcase
  end

  always_comb begin
    strobe.legacyPci = !ctlReg[OPEN_BIT] || extReg[HIGH_BIT];
    strobe.highOpen  = ctlReg[OPEN_BIT] && extReg[HIGH_BIT];
    strobe.smmLow    = ctlReg[GEN_BIT] && !extReg[HIGH_BIT];
    strobe.smmHigh   = ctlReg[GEN_BIT] && extReg[HIGH_BIT];
    if (!extReg[TEN_BIT]) strobe.tsegMb = '0;
    else begin
      case (extReg[SZ_LO +: 2])
        2'd0:    strobe.tsegMb = 12'd1;
        2'd1:    strobe.tsegMb = 12'd2;
        2'd2:    strobe.tsegMb = 12'd8;
        default: strobe.tsegMb = 12'(EXT_EFF);
      endcase
    end
  end

  // R3: lock is sticky until reset
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[LOCK_BIT] |=> ctlReg[LOCK_BIT]);
  // R3: a locked configuration never has the open bit set
  assert_lock_closed_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[LOCK_BIT] |-> !ctlReg[OPEN_BIT]);
  // R3: both control bytes are frozen once locked
  assert_lock_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[LOCK_BIT] |=> ($stable(ctlReg) && $stable(extReg)));
  // R9: a query write is answered with the configured size
  assert_query_reply_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == SEL_WORD && cfgWrData == QUERY && EXT_EFF > 0)
      |=> (cfgAddr != SEL_WORD || cfgRdData == EXT_WORD));
endmodule

// File: rtl/smram_decode.sv
module smram_decode
  import smram_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] TOP_LOW_RAM = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  win_strobe_t       strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  output logic [1:0]        accRoute,
  output logic [ADDR_W-1:0] ramAddr
);
  localparam logic [ADDR_W-1:0] LEG_LO  = ADDR_W'(LEGACY_BASE);
  localparam logic [ADDR_W-1:0] LEG_HI  = ADDR_W'(LEGACY_BASE + WINDOW_SIZE);
  localparam logic [ADDR_W-1:0] HIGH_LO = ADDR_W'(HIGH_BASE);
  localparam logic [ADDR_W-1:0] HIGH_HI = ADDR_W'(HIGH_BASE + WINDOW_SIZE);

  logic [ADDR_W-1:0] tsegBytes, tsegBase, highMapped;
  logic inLegacy, inHigh, inTseg;
  route_e route;

  assign tsegBytes  = ADDR_W'(strobe.tsegMb) << 20;
  assign tsegBase   = TOP_LOW_RAM - tsegBytes;
  assign inLegacy   = (accAddr >= LEG_LO) && (accAddr < LEG_HI);
  assign inHigh     = (accAddr >= HIGH_LO) && (accAddr < HIGH_HI);
  assign inTseg     = (strobe.tsegMb != '0) && (accAddr >= tsegBase) && (accAddr < TOP_LOW_RAM);
  assign highMapped = accAddr - HIGH_LO + LEG_LO;

  always_comb begin
    route   = ROUTE_PASS;
    ramAddr = accAddr;
    if (accSmm && strobe.smmLow && inLegacy) begin
      route = ROUTE_RAM;
    end else if (accSmm && strobe.smmHigh && inHigh) begin
      route   = ROUTE_RAM;
      ramAddr = highMapped;
    end else if (inTseg) begin
      route = accSmm ? ROUTE_RAM : ROUTE_HOLE;
    end else if (inLegacy) begin
      route = strobe.legacyPci ? ROUTE_PCI : ROUTE_RAM;
    end else if (inHigh && strobe.highOpen) begin
      route   = ROUTE_RAM;
      ramAddr = highMapped;
    end
  end

  assign accRoute = route;

  // R8: the discard hole is never seen by system-management accesses
  assert_hole_normal_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accRoute == ROUTE_HOLE) |-> !accSmm);
  // R4: PCI/video routing only happens inside the legacy window
  assert_pci_in_legacy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accRoute == ROUTE_PCI) |-> (accAddr >= LEG_LO && accAddr < LEG_HI));
  // R5: a pass route leaves the address untouched
  assert_pass_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accRoute == ROUTE_PASS) |-> (ramAddr == accAddr));
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_pkg::*;
#(
  parameter int                ADDR_W          = 32,
  parameter int                WORD_W          = 16,
  parameter logic [ADDR_W-1:0] TOP_LOW_RAM     = 32'h8000_0000,
  parameter int                EXT_TSEG_MB     = 16,
  parameter int                EXT_TSEG_MAX_MB = 4095
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] cfgRdData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSmm,
  output logic [1:0]        accRoute,
  output logic [ADDR_W-1:0] ramAddr
);
  win_strobe_t strobe;

  smram_ctrl #(
    .WORD_W(WORD_W), .EXT_TSEG_MB(EXT_TSEG_MB), .EXT_TSEG_MAX_MB(EXT_TSEG_MAX_MB)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .strobe(strobe)
  );

  smram_decode #(
    .ADDR_W(ADDR_W), .TOP_LOW_RAM(TOP_LOW_RAM)
  ) decode_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accAddr(accAddr),
    .accSmm(accSmm), .accRoute(accRoute), .ramAddr(ramAddr)
  );
endmodule

// File: tb/smram_guard_tb.sv
`timescale 1ns/1ps
module smram_guard_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [15:0] cfgWrData = 16'd0;
  logic [15:0] cfgRdData;
  logic [31:0] accAddr = 32'd0;
  logic accSmm = 1'b0;
  logic [1:0] accRoute;
  logic [31:0] ramAddr;

  int checks = 0;
  int fails = 0;

  // reference state
  logic [7:0] mCtl, mExt;
  logic [15:0] mWord;

  always #2 clk = ~clk;

  smram_guard dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .accAddr(accAddr),
    .accSmm(accSmm), .accRoute(accRoute), .ramAddr(ramAddr)
  );

  function automatic longint segBytes();
    if (!mExt[0]) return 0;
    case (mExt[2:1])
      2'd0: return 64'd1 << 20;
      2'd1: return 64'd2 << 20;
      2'd2: return 64'd8 << 20;
      default: return 64'd16 << 20;
    endcase
  endfunction

  function automatic void refRoute(input logic [31:0] a, input logic smm,
                                   output logic [1:0] r, output logic [31:0] ra);
    longint ad = longint'(a);
    bit legacy = (ad >= 64'hA0000) && (ad < 64'hC0000);
    bit high   = (ad >= 64'hFEDA0000) && (ad < 64'hFEDC0000);
    bit seg    = (segBytes() != 0) && (ad >= 64'h80000000 - segBytes()) && (ad < 64'h80000000);
    bit openB  = mCtl[6];
    bit hiSel  = mExt[7];
    r = 2'd0;
    ra = a;
    if (smm && mCtl[3] && !hiSel && legacy) r = 2'd1;
    else if (smm && mCtl[3] && hiSel && high) begin r = 2'd1; ra = a - 32'hFED00000; end
    else if (seg) r = smm ? 2'd1 : 2'd3;
    else if (legacy) r = (openB && !hiSel) ? 2'd1 : 2'd2;
    else if (high && openB && hiSel) begin r = 2'd1; ra = a - 32'hFED00000; end
  endfunction

  function automatic logic [15:0] refRead(input logic [1:0] sel);
    case (sel)
      2'd0: return {8'd0, mCtl};
      2'd1: return {8'd0, mExt};
      2'd2: return mWord;
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [1:0] sel, input logic [15:0] data,
                     input logic [31:0] a, input bit smm, input string tag);
    logic [1:0] er;
    logic [31:0] ea;
    @(negedge clk);
    cfgWrEn = we; cfgAddr = sel; cfgWrData = data; accAddr = a; accSmm = smm;
    #1;
    refRoute(a, smm, er, ea);
    check(tag, "read", {16'd0, cfgRdData}, {16'd0, refRead(sel)});
    check(tag, "route", {30'd0, accRoute}, {30'd0, er});
    check(tag, "ramAddr", ramAddr, ea);
    @(posedge clk);
    if (we) begin
      case (sel)
        2'd0: if (!mCtl[4]) begin
          mCtl = data[7:0] & 8'h58;
          if (mCtl[4]) mCtl[6] = 1'b0;
        end
        2'd1: if (!mCtl[4]) mExt = data[7:0] & 8'h87;
        2'd2: mWord = (data == 16'hFFFF) ? 16'd16 : data;
        default: ;
      endcase
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgWrEn = 1'b0;
    repeat (3) @(negedge clk);
    mCtl = 8'h00; mExt = 8'h00; mWord = 16'hFFFF;
    rstN = 1'b1;
  endtask

  task automatic look(input logic [31:0] a, input bit smm, input string tag);
    cyc(1'b0, 2'd0, 16'd0, a, smm, tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset values
    cyc(1'b0, 2'd0, 0, 32'h0, 0, "R1");
    cyc(1'b0, 2'd1, 0, 32'h0, 0, "R1");
    cyc(1'b0, 2'd2, 0, 32'h0, 0, "R1");
    // R2 write masks
    cyc(1'b1, 2'd0, 16'hFFAF, 32'h0, 0, "R2");
    cyc(1'b1, 2'd1, 16'hFFFF, 32'h0, 0, "R2");
    cyc(1'b0, 2'd0, 0, 32'h0, 0, "R2");
    cyc(1'b0, 2'd1, 0, 32'h0, 0, "R2");
    cyc(1'b1, 2'd0, 16'h0000, 32'h0, 0, "R2");
    cyc(1'b1, 2'd1, 16'h0000, 32'h0, 0, "R2");
    // R4 legacy window, ordinary mode
    look(32'h000A0000, 0, "R4");
    look(32'h000BFFFF, 0, "R4");
    look(32'h000C0000, 0, "R4");
    cyc(1'b1, 2'd0, 16'h0040, 32'h0, 0, "R4");
    look(32'h000A0000, 0, "R4");
    look(32'h0009FFFF, 0, "R4");
    // R5 high window
    look(32'hFEDA1234, 0, "R5");
    cyc(1'b1, 2'd1, 16'h0080, 32'h0, 0, "R5");
    look(32'hFEDA1234, 0, "R5");
    look(32'hFEDBFFFF, 0, "R5");
    look(32'hFEDC0000, 0, "R5");
    look(32'h000A0010, 0, "R4");
    look(32'h00001000, 0, "R5");
    // R6 system-management views
    cyc(1'b1, 2'd0, 16'h0008, 32'h0, 0, "R6");
    look(32'hFEDA0010, 1, "R6");
    look(32'h000A0010, 1, "R6");
    look(32'hFEDA0010, 0, "R6");
    cyc(1'b1, 2'd1, 16'h0000, 32'h0, 0, "R6");
    look(32'h000B0000, 1, "R6");
    look(32'hFEDA0010, 1, "R6");
    cyc(1'b1, 2'd0, 16'h0000, 32'h0, 0, "R6");
    look(32'h000B0000, 1, "R6");
    // R7 / R8 protected segment
    look(32'h7FFFFFF0, 0, "R7");
    cyc(1'b1, 2'd1, 16'h0001, 32'h0, 0, "R7");
    look(32'h7FF00000, 0, "R8");
    look(32'h7FEFFFFF, 0, "R7");
    look(32'h7FF00000, 1, "R8");
    look(32'h80000000, 0, "R8");
    cyc(1'b1, 2'd1, 16'h0003, 32'h0, 0, "R7");
    look(32'h7FE00000, 0, "R7");
    look(32'h7FDFFFFF, 0, "R7");
    cyc(1'b1, 2'd1, 16'h0005, 32'h0, 0, "R7");
    look(32'h7F800000, 0, "R7");
    look(32'h7F7FFFFF, 0, "R7");
    look(32'h7F900000, 1, "R8");
    cyc(1'b1, 2'd1, 16'h0007, 32'h0, 0, "R7");
    look(32'h7F000000, 0, "R7");
    look(32'h7EFFFFFF, 0, "R7");
    cyc(1'b1, 2'd1, 16'h0006, 32'h0, 0, "R7");
    look(32'h7FFFFFF0, 0, "R7");
    // R9 size word
    cyc(1'b1, 2'd2, 16'h1234, 32'h0, 0, "R9");
    cyc(1'b0, 2'd2, 0, 32'h0, 0, "R9");
    cyc(1'b1, 2'd2, 16'hFFFF, 32'h0, 0, "R9");
    cyc(1'b0, 2'd2, 0, 32'h0, 0, "R9");
    // R3 lock
    cyc(1'b1, 2'd1, 16'h0000, 32'h0, 0, "R3");
    cyc(1'b1, 2'd0, 16'h0058, 32'h0, 0, "R3");
    cyc(1'b0, 2'd0, 0, 32'h000A0000, 0, "R3");
    cyc(1'b1, 2'd0, 16'h0040, 32'h0, 0, "R3");
    cyc(1'b0, 2'd0, 0, 32'h000A0000, 0, "R3");
    cyc(1'b1, 2'd1, 16'h0087, 32'h0, 0, "R3");
    cyc(1'b0, 2'd1, 0, 32'h7FFFFFF0, 0, "R3");
    look(32'h000A0000, 1, "R3");
    // R1 reset clears the lock
    doReset();
    cyc(1'b0, 2'd0, 0, 32'h0, 0, "R1");
    cyc(1'b1, 2'd0, 16'h0040, 32'h0, 0, "R1");
    look(32'h000A0000, 0, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule